// File: doc/BRIEF.md
# Tile-Ownership Fragment Work Dispatcher

This block sits between a setup/raster stage and a set of independent shader pipes. Each incoming work item carries a pixel position and a triangle number. The block works out which 16x16 screen tile the pixel lies in and which pipe owns that tile. It then writes the item into that pipe's private queue. Each pipe drains its own queue through its own valid/ready pair. Because the queues are deep and separate, one pipe may run hundreds of items ahead of another in triangle order.

Tile ownership is a fixed function of the linear tile number and a set of per-pipe capacity weights. The tile number is reduced modulo the sum of the weights, and the remainder is compared against cumulative thresholds. Any other agent that knows the weights can compute the same map with no exchange of messages. The weights are loaded through a configuration strobe. A weight set that contains a zero, or whose sum exceeds 16, is refused and the previous map stays in force.

Top module: `frag_tile_router`

## Requirements
- R1: The tile column is in_x shifted right by 4 and the tile row is in_y shifted right by 4. The linear tile number is row * TILES_PER_ROW + column. Pixels that differ only in their low 4 coordinate bits therefore go to the same pipe.
- R2: The owner is computed as follows. Let s be the linear tile number modulo the sum of the active weights. The owner is the lowest pipe p for which s < w0 + ... + wp. After reset every weight is 1.
- R3: Every accepted item (in_valid and in_ready both high at a rising edge) appears on exactly one output: the owner's. No output presents an item that was never accepted for it.
- R4: Each pipe's output delivers its items unchanged (x, y, triangle) and in the order they were accepted.
- R5: in_ready is low exactly when the owner of the presented tile already holds FIFO_DEPTH items behind its output stage, that is, occupancy minus out_valid equals FIFO_DEPTH. A full queue on any other pipe never lowers in_ready.
- R6: While out_valid[p] is high and out_ready[p] is low, out_valid[p] and that pipe's data stay unchanged at the next edge.
- R7: A one-cycle cfg_load pulse offers new weights. The weight for pipe p is cfg_weights[p*WEIGHT_W +: WEIGHT_W]. The set is taken only if every weight is nonzero and their sum is at most 16; otherwise it is ignored. Items presented from the next cycle on use the accepted weights.
- R8: out_occ[p*OCC_W +: OCC_W] equals the number of items held for pipe p, including the one at its output. At most FIFO_DEPTH+1 items are held.
- R9: After synchronous reset every out_valid is low, every occupancy is 0 and in_ready is high.
- R10: Over any run of consecutive linear tile numbers as long as the weight sum, each pipe receives exactly its weight in tiles. For example, weights 1, 2, 3 give 1, 2 and 3 of six tiles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Strobe offering a new weight set |
| cfg_weights | input | NUM_PIPES*WEIGHT_W | Per-pipe capacity weights, pipe 0 in the low bits |
| in_valid | input | 1 | Work item present |
| in_ready | output | 1 | Work item taken this cycle |
| in_x | input | COORD_W | Pixel column |
| in_y | input | COORD_W | Pixel row |
| in_tri | input | TRI_W | Triangle number |
| out_valid | output | NUM_PIPES | Per-pipe item present |
| out_ready | input | NUM_PIPES | Per-pipe consumer ready |
| out_x | output | NUM_PIPES*COORD_W | Per-pipe pixel column |
| out_y | output | NUM_PIPES*COORD_W | Per-pipe pixel row |
| out_tri | output | NUM_PIPES*TRI_W | Per-pipe triangle number |
| out_occ | output | NUM_PIPES*OCC_W | Per-pipe items held |

## Verification
The bench builds the block with three pipes, five tiles per row and a queue depth of 4. This choice has two effects. A non-power-of-two weight sum such as 6 exercises the modulo path. A single stalled pipe fills after five items, so the full-queue stall and the rule that a full queue on one pipe never blocks another can both be reached in a few cycles. The weight sets 1,1,1 and 1,2,3 give hand-computable owners. Two refused sets are applied: one with a zero weight and one summing to 17. Both would move tile 3 to a different pipe if they were wrongly accepted. Randomised per-pipe back-pressure then drives the queues through long stretches of independent drift.

// File: rtl/frag_route_pkg.sv
package frag_route_pkg;
  // Tile edge is 16 pixels.
  localparam int TILE_SHIFT = 4;
  // Upper bound on the sum of capacity weights.
  localparam int WSUM_LIMIT = 16;
  localparam int SUM_W      = $clog2(WSUM_LIMIT + 1);
endpackage

// File: rtl/tile_owner_map.sv
module tile_owner_map
  import frag_route_pkg::*;
#(
  parameter int NUM_PIPES     = 4,
  parameter int WEIGHT_W      = 5,
  parameter int COORD_W       = 12,
  parameter int TILES_PER_ROW = 8,
  parameter int PIPE_W        = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_load,
  input  logic [NUM_PIPES*WEIGHT_W-1:0] cfg_weights,
  input  logic [COORD_W-1:0]            px,
  input  logic [COORD_W-1:0]            py,
  output logic [PIPE_W-1:0]             owner
);
  localparam int TIDX_W = COORD_W - TILE_SHIFT;

  logic [SUM_W-1:0] cum_q [NUM_PIPES];
  logic [SUM_W-1:0] cum_d [NUM_PIPES];
  logic             cfg_ok;

  // Cumulative thresholds of the offered set, plus its validity.
  always_comb begin
    int acc;
    acc    = 0;
    cfg_ok = 1'b1;
    for (int p = 0; p < NUM_PIPES; p++) begin
      if (cfg_weights[p*WEIGHT_W +: WEIGHT_W] == '0) cfg_ok = 1'b0;
      acc      = acc + int'(cfg_weights[p*WEIGHT_W +: WEIGHT_W]);
      cum_d[p] = SUM_W'(acc);
    end
    if (acc > WSUM_LIMIT) cfg_ok = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PIPES; p++) cum_q[p] <= SUM_W'(p + 1);
    end else if (cfg_load && cfg_ok) begin
      for (int p = 0; p < NUM_PIPES; p++) cum_q[p] <= cum_d[p];
    end
  end

  logic [TIDX_W-1:0] tcol, trow;
  logic [31:0]       lin, slot;

  assign tcol = px[COORD_W-1:TILE_SHIFT];
  assign trow = py[COORD_W-1:TILE_SHIFT];
  assign lin  = 32'(trow) * 32'(TILES_PER_ROW) + 32'(tcol);
  assign slot = lin % 32'(cum_q[NUM_PIPES-1]);

  // Lowest pipe whose threshold exceeds the slot wins.
  always_comb begin
    owner = PIPE_W'(NUM_PIPES - 1);
    for (int p = NUM_PIPES - 1; p >= 0; p--) begin
      if (slot < 32'(cum_q[p])) owner = PIPE_W'(p);
    end
  end
endmodule

// File: rtl/frag_fifo.sv
module frag_fifo #(
  parameter int DATA_W = 40,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int OCC_W  = $clog2(DEPTH + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic              full,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [OCC_W-1:0]  occ
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;
  logic              ov;
  logic              pull;

  assign full = (cnt == CNT_W'(DEPTH));
  assign pull = (cnt != '0) && (!ov || out_ready);

  // Storage array: write port and registered read port, no reset.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
    if (pull) out_data    <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ov     <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == ADDR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pull) rd_ptr <= (rd_ptr == ADDR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pull);
      if (pull)           ov <= 1'b1;
      else if (out_ready) ov <= 1'b0;
    end
  end

  assign out_valid = ov;
  assign occ       = OCC_W'(cnt) + OCC_W'(ov);
endmodule

// File: rtl/frag_tile_router.sv
module frag_tile_router
  import frag_route_pkg::*;
#(
  parameter int NUM_PIPES     = 4,
  parameter int WEIGHT_W      = 5,
  parameter int COORD_W       = 12,
  parameter int TRI_W         = 16,
  parameter int TILES_PER_ROW = 8,
  parameter int FIFO_DEPTH    = 256,
  parameter int OCC_W         = $clog2(FIFO_DEPTH + 2)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_load,
  input  logic [NUM_PIPES*WEIGHT_W-1:0] cfg_weights,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [COORD_W-1:0]            in_x,
  input  logic [COORD_W-1:0]            in_y,
  input  logic [TRI_W-1:0]              in_tri,
  output logic [NUM_PIPES-1:0]          out_valid,
  input  logic [NUM_PIPES-1:0]          out_ready,
  output logic [NUM_PIPES*COORD_W-1:0]  out_x,
  output logic [NUM_PIPES*COORD_W-1:0]  out_y,
  output logic [NUM_PIPES*TRI_W-1:0]    out_tri,
  output logic [NUM_PIPES*OCC_W-1:0]    out_occ
);
  localparam int PIPE_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1;
  localparam int ITEM_W = 2 * COORD_W + TRI_W;

  logic [PIPE_W-1:0]    route_pipe;
  logic [NUM_PIPES-1:0] full_vec;
  logic [NUM_PIPES-1:0] push_vec;
  logic [ITEM_W-1:0]    item;

  tile_owner_map #(
    .NUM_PIPES    (NUM_PIPES),
    .WEIGHT_W     (WEIGHT_W),
    .COORD_W      (COORD_W),
    .TILES_PER_ROW(TILES_PER_ROW),
    .PIPE_W       (PIPE_W)
  ) owner_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_load   (cfg_load),
    .cfg_weights(cfg_weights),
    .px         (in_x),
    .py         (in_y),
    .owner      (route_pipe)
  );

  // Only the owning pipe's queue can hold the input back.
  assign in_ready = !full_vec[route_pipe];
  assign item     = {in_x, in_y, in_tri};

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    logic [ITEM_W-1:0] q_data;

    assign push_vec[p] = in_valid && in_ready && (route_pipe == PIPE_W'(p));

    frag_fifo #(
      .DATA_W(ITEM_W),
      .DEPTH (FIFO_DEPTH),
      .OCC_W (OCC_W)
    ) q_i (
      .clk      (clk),
      .rst      (rst),
      .push     (push_vec[p]),
      .push_data(item),
      .full     (full_vec[p]),
      .out_valid(out_valid[p]),
      .out_ready(out_ready[p]),
      .out_data (q_data),
      .occ      (out_occ[p*OCC_W +: OCC_W])
    );

    assign out_x[p*COORD_W +: COORD_W] = q_data[ITEM_W-1 -: COORD_W];
    assign out_y[p*COORD_W +: COORD_W] = q_data[TRI_W +: COORD_W];
    assign out_tri[p*TRI_W +: TRI_W]   = q_data[TRI_W-1:0];
  end
endmodule

// File: rtl/frag_router_chk.sv
module frag_router_chk #(
  parameter int NUM_PIPES  = 4,
  parameter int COORD_W    = 12,
  parameter int TRI_W      = 16,
  parameter int FIFO_DEPTH = 256,
  parameter int OCC_W      = 9,
  parameter int PIPE_W     = 2
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_valid,
  input logic                         in_ready,
  input logic [PIPE_W-1:0]            route_pipe,
  input logic [NUM_PIPES-1:0]         push_vec,
  input logic [NUM_PIPES-1:0]         out_valid,
  input logic [NUM_PIPES-1:0]         out_ready,
  input logic [NUM_PIPES*COORD_W-1:0] out_x,
  input logic [NUM_PIPES*COORD_W-1:0] out_y,
  input logic [NUM_PIPES*TRI_W-1:0]   out_tri,
  input logic [NUM_PIPES*OCC_W-1:0]   out_occ
);
  logic past_rst_q = 1'b0;
  always_ff @(posedge clk) past_rst_q <= rst;

  // R9
  always_ff @(posedge clk) begin
    if (past_rst_q && !rst) begin
      reset_state_chk: assert (out_valid == '0 && out_occ == '0 && in_ready)
        else $error("reset state wrong");
    end
  end

  // R3
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    (push_vec != '0) |-> (in_valid && $onehot0(push_vec)));

  // R5
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |->
      ((OCC_W+1)'(out_occ[route_pipe*OCC_W +: OCC_W]) -
       (OCC_W+1)'(out_valid[route_pipe]) == (OCC_W+1)'(FIFO_DEPTH)));

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_chk
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid[p] && !out_ready[p]) |=>
        (out_valid[p] && $stable(out_tri[p*TRI_W +: TRI_W]) &&
         $stable(out_x[p*COORD_W +: COORD_W]) && $stable(out_y[p*COORD_W +: COORD_W])));
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      out_occ[p*OCC_W +: OCC_W] <= OCC_W'(FIFO_DEPTH + 1));
    // R8
    valid_backed_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid[p] |-> (out_occ[p*OCC_W +: OCC_W] != '0));
  end
endmodule

bind frag_tile_router frag_router_chk #(
  .NUM_PIPES (NUM_PIPES),
  .COORD_W   (COORD_W),
  .TRI_W     (TRI_W),
  .FIFO_DEPTH(FIFO_DEPTH),
  .OCC_W     (OCC_W),
  .PIPE_W    (PIPE_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .route_pipe(route_pipe),
  .push_vec  (push_vec),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_x     (out_x),
  .out_y     (out_y),
  .out_tri   (out_tri),
  .out_occ   (out_occ)
);

// File: tb/frag_tile_router_tb_top.sv
module frag_tile_router_tb_top;
  localparam int NP    = 3;
  localparam int WW    = 5;
  localparam int CW    = 10;
  localparam int TW    = 8;
  localparam int TPR   = 5;
  localparam int DEPTH = 4;
  localparam int OW    = $clog2(DEPTH + 2);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_load = 1'b0;
  logic [NP*WW-1:0] cfg_w = '0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [CW-1:0]   in_x = '0, in_y = '0;
  logic [TW-1:0]   in_tri = '0;
  logic [NP-1:0]   out_valid, out_ready;
  logic [NP*CW-1:0] out_x, out_y;
  logic [NP*TW-1:0] out_tri;
  logic [NP*OW-1:0] out_occ;

  always #4 clk = ~clk;

  frag_tile_router #(
    .NUM_PIPES(NP), .WEIGHT_W(WW), .COORD_W(CW), .TRI_W(TW),
    .TILES_PER_ROW(TPR), .FIFO_DEPTH(DEPTH), .OCC_W(OW)
  ) dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_weights(cfg_w),
    .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y),
    .in_tri(in_tri), .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_tri(out_tri), .out_occ(out_occ)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit rand_on = 0;
  logic [NP-1:0] ready_force = '1;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model
  int mw[NP];
  logic [2*CW+TW-1:0] mq[NP][$];
  int last_pipe = -1, last_tri = -1;
  int got[NP];

  function automatic int owner_of(int x, int y);
    int lin, s, acc;
    lin = (y / 16) * TPR + (x / 16);
    s = 0;
    for (int p = 0; p < NP; p++) s += mw[p];
    lin = lin % s;
    acc = 0;
    for (int p = 0; p < NP; p++) begin
      acc += mw[p];
      if (lin < acc) return p;
    end
    return NP - 1;
  endfunction

  always @(posedge clk) begin
    #1;
    out_ready = rand_on ? NP'($urandom) : ready_force;
  end

  always @(negedge clk) begin
    if (rst) begin
      for (int p = 0; p < NP; p++) begin mw[p] = 1; mq[p].delete(); end
    end else if (!done) begin
      int tgt;
      tgt = owner_of(int'(in_x), int'(in_y));
      chk(in_ready == ((mq[tgt].size() - int'(out_valid[tgt])) < DEPTH),
          "R5 in_ready", int'(in_ready), int'((mq[tgt].size() - int'(out_valid[tgt])) < DEPTH));
      for (int p = 0; p < NP; p++) begin
        chk(int'(out_occ[p*OW +: OW]) == mq[p].size(), "R8 occupancy",
            int'(out_occ[p*OW +: OW]), mq[p].size());
        if (out_valid[p]) begin
          if (mq[p].size() == 0) chk(0, "R3 unexpected item", p, -1);
          else if (out_ready[p]) begin
            logic [2*CW+TW-1:0] e;
            e = mq[p].pop_front();
            chk({out_x[p*CW +: CW], out_y[p*CW +: CW], out_tri[p*TW +: TW]} == e,
                "R4 item/order", int'(out_tri[p*TW +: TW]), int'(e[TW-1:0]));
            last_pipe = p;
            last_tri  = int'(out_tri[p*TW +: TW]);
            got[p]++;
          end
        end
      end
      if (in_valid && in_ready) mq[tgt].push_back({in_x, in_y, in_tri});
      if (cfg_load) begin
        int s; bit ok;
        s = 0; ok = 1;
        for (int p = 0; p < NP; p++) begin
          s += int'(cfg_w[p*WW +: WW]);
          if (cfg_w[p*WW +: WW] == '0) ok = 0;
        end
        if (ok && s <= 16) for (int p = 0; p < NP; p++) mw[p] = int'(cfg_w[p*WW +: WW]);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send(int x, int y, int t);
    @(posedge clk); #2;
    in_valid = 1; in_x = CW'(x); in_y = CW'(y); in_tri = TW'(t);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 0;
  endtask

  task automatic route_chk(int x, int y, int t, int exp_pipe, string tag);
    send(x, y, t);
    idle(5);
    chk(last_tri == t && last_pipe == exp_pipe, tag, last_pipe, exp_pipe);
  endtask

  task automatic load_cfg(int a, int b, int c);
    @(posedge clk); #2;
    cfg_load = 1;
    cfg_w = {WW'(c), WW'(b), WW'(a)};
    @(posedge clk); #2;
    cfg_load = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(out_valid == '0, "R9 out_valid", int'(out_valid), 0);
    chk(out_occ == '0, "R9 occupancy", int'(out_occ), 0);
    @(posedge clk); #2;
    rst = 0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);

    // Default weights 1,1,1
    route_chk(67, 25, 1, 0, "R2 tile 9 -> pipe 0");
    route_chk(20, 0, 2, 1, "R2 tile 1 -> pipe 1");
    route_chk(31, 15, 3, 1, "R1 pixel (31,15) tile 1");
    route_chk(32, 15, 4, 2, "R1 pixel (32,15) tile 2");

    // Weights 1,2,3
    load_cfg(1, 2, 3);
    route_chk(32, 16, 5, 1, "R7 tile 7 -> pipe 1");
    route_chk(16, 32, 6, 2, "R7 tile 11 -> pipe 2");

    // R10 share over six consecutive tiles
    for (int p = 0; p < NP; p++) got[p] = 0;
    for (int i = 0; i < 6; i++) send((i % TPR) * 16 + 5, (i / TPR) * 16 + 3, 10 + i);
    idle(6);
    chk(got[0] == 1, "R10 pipe 0 share", got[0], 1);
    chk(got[1] == 2, "R10 pipe 1 share", got[1], 2);
    chk(got[2] == 3, "R10 pipe 2 share", got[2], 3);

    // Refused configurations
    load_cfg(0, 5, 5);
    route_chk(48, 0, 20, 2, "R7 zero weight refused");
    load_cfg(9, 4, 4);
    route_chk(48, 0, 21, 2, "R7 sum 17 refused");

    // Stall pipe 0 only
    ready_force = 3'b110;
    for (int i = 0; i < DEPTH + 1; i++) send(16 * (i % 2), 16 * (i % 2), 30 + i);
    idle(2);
    chk(int'(out_occ[0 +: OW]) == DEPTH + 1, "R8 full occupancy", int'(out_occ[0 +: OW]), DEPTH + 1);
    chk(out_valid[0] && out_tri[0 +: TW] == TW'(30), "R6 held item", int'(out_tri[0 +: TW]), 30);
    in_valid = 1; in_x = '0; in_y = '0; in_tri = TW'(40);
    idle(3);
    chk(in_ready == 1'b0, "R5 stall on full owner", int'(in_ready), 0);
    chk(out_valid[0] && out_tri[0 +: TW] == TW'(30), "R6 held after stall", int'(out_tri[0 +: TW]), 30);
    in_valid = 0;
    route_chk(48, 0, 41, 2, "R5 other pipe not blocked");
    ready_force = '1;
    idle(12);
    chk(out_occ[0 +: OW] == '0, "R4 stalled pipe drained", int'(out_occ[0 +: OW]), 0);

    // Random traffic with random back-pressure
    load_cfg(2, 4, 6);
    rand_on = 1;
    for (int i = 0; i < 400; i++) send(int'($urandom % (TPR * 16)), int'($urandom % 64), i % 256);
    rand_on = 0;
    idle(30);
    for (int p = 0; p < NP; p++)
      chk(out_occ[p*OW +: OW] == '0, "R3 all delivered", int'(out_occ[p*OW +: OW]), 0);

    done = 1;
    summary();
  end
endmodule